// File: doc/BRIEF.md
# Prefixed Instruction Fusion Stage

This stage sits at the front of instruction decode for a 32-bit fixed-length instruction set that also has 64-bit prefixed instructions. Each cycle it may receive one instruction word. The word comes with a valid bit, a code from the predecoder and its fetch address. A word whose top six bits equal 1 is a prefix. The stage keeps such a word and sends nothing downstream in that cycle. The next valid word is the suffix, and the stage combines the two into one fused operation.

The fused operation carries four things. The first is the suffix code with its least significant bit set, since every code that can follow a prefix is even and its prefixed form is the next odd value. The second is the address of the prefix, built by writing the saved prefix address bits 5:2 over the suffix address; no prefixed instruction crosses a 64-byte boundary. The third is a 34-bit displacement, sign-extended to 64 bits. The fourth is a PC-relative flag and a flag that says whether the prefix form suits the suffix. Words that are not part of a prefixed pair go through unchanged. All outputs are registered, and there is no handshake.

Top module: `prefix_fuse`

## Requirements
- R1: A valid word with bits 31:26 equal to 1 that arrives while no prefix is pending becomes the pending prefix. No output is valid in the next cycle.
- R2: Cycles with `in_valid` low leave a pending prefix in place and produce no output. The next valid word is then used as its suffix.
- R3: A valid non-prefix word that arrives while a prefix is pending produces a fused output one cycle later. It has `out_prefixed`=1, `out_code` equal to the suffix code with bit 0 set, and `out_word` equal to the suffix word.
- R4: The fused `out_addr` equals the suffix address with bits 5:2 replaced by bits 5:2 of the prefix address.
- R5: The fused `out_imm` is the 34-bit value {prefix bits 17:0, suffix bits 15:0}, sign-extended from bit 33 to 64 bits.
- R6: For a fused output, `out_pcrel` equals prefix bit 20 when the prefix form field (bits 25:24) is 00 or 10. For any other form it is 0. It is 0 for unprefixed outputs.
- R7: For a fused output, `out_pfx_ok` is 1 when the form field is 00, or when it is 10 and prefix bit 23 is 0. Otherwise it is 0, and the fused code still follows R3. It is 0 for unprefixed outputs.
- R8: An unprefixed word is marked `out_illegal` when its code equals ILLEGAL_CODE (default 0) or one of the two placeholder codes (defaults 200 and 202). As a suffix, a placeholder code fuses to the next odd code and is not illegal.
- R9: A prefix that arrives while a prefix is pending produces, one cycle later, an output with `out_valid`=1, `out_prefixed`=1 and `out_illegal`=1. It leaves no prefix pending.
- R10: `flush` drops any pending prefix and any input in the same cycle. No output is valid in the next cycle.
- R11: A valid non-prefix word with no prefix pending appears one cycle later with the same code, word and address. It has `out_prefixed`=0 and `out_imm` equal to word bits 15:0 sign-extended.
- R12: After reset, `out_valid` is 0 and no prefix is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drops pending prefix and current input |
| in_valid | input | 1 | Input word is valid |
| in_word | input | 32 | Instruction word |
| in_code | input | CODE_W | Predecoded instruction code |
| in_addr | input | ADDR_W | Fetch address of the word |
| out_valid | output | 1 | Output operation valid |
| out_word | output | 32 | Instruction word (the suffix for fused ops) |
| out_code | output | CODE_W | Instruction code, LSB set when fused |
| out_addr | output | ADDR_W | Instruction address (prefix address when fused) |
| out_prefixed | output | 1 | Operation came from a prefix and suffix pair |
| out_pfx_ok | output | 1 | Prefix form suits the suffix |
| out_pcrel | output | 1 | PC-relative addressing selected |
| out_illegal | output | 1 | Operation is illegal |
| out_imm | output | 64 | Sign-extended displacement |

## Verification
A wrong pending-prefix flag shows at the ports in the cycle after the next valid word. A missed prefix produces an unprefixed output with an even code and its own address. A stuck flag produces a fused output for a plain word, or an illegal double-prefix output. Bad saved prefix fields show only on the fused output that follows: wrong bits 5:2 of the address, wrong upper displacement bits or sign, or wrong PC-relative and form-check flags. So each scenario sends a prefix, optionally waits through idle or flush cycles, and then checks the single output that follows the suffix.

// File: rtl/prefix_fuse.sv
module prefix_fuse #(
  parameter int CODE_W = 10,
  parameter int ADDR_W = 64,
  parameter int OVL_HI = 5,
  parameter logic [CODE_W-1:0] ILLEGAL_CODE = '0,
  parameter logic [CODE_W-1:0] PH_LOAD_CODE = CODE_W'(200),
  parameter logic [CODE_W-1:0] PH_STORE_CODE = CODE_W'(202)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  input  logic [CODE_W-1:0] in_code,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic [CODE_W-1:0] out_code,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_prefixed,
  output logic              out_pfx_ok,
  output logic              out_pcrel,
  output logic              out_illegal,
  output logic [63:0]       out_imm
);
  localparam int OVL_W = OVL_HI - 1;
  localparam int DISP_W = 34;

  logic              pend;
  logic [17:0]       p_disp;
  logic [1:0]        p_form;
  logic              p_sub;
  logic              p_rel;
  logic [OVL_W-1:0]  p_lo;

  logic              is_pfx;
  logic              form_ls;
  logic              form_ok;
  logic [ADDR_W-1:0] fused_addr;
  logic [DISP_W-1:0] disp34;

  assign is_pfx  = in_word[31:26] == 6'd1;
  assign form_ls = (p_form == 2'b00) || (p_form == 2'b10);
  assign form_ok = (p_form == 2'b00) || (p_form == 2'b10 && !p_sub);
  assign disp34  = {p_disp, in_word[15:0]};

  always_comb begin
    fused_addr = in_addr;
    fused_addr[OVL_HI:2] = p_lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      out_valid <= 1'b0;
      p_disp <= '0;
      p_form <= '0;
      p_sub <= 1'b0;
      p_rel <= 1'b0;
      p_lo <= '0;
      out_word <= '0;
      out_code <= '0;
      out_addr <= '0;
      out_prefixed <= 1'b0;
      out_pfx_ok <= 1'b0;
      out_pcrel <= 1'b0;
      out_illegal <= 1'b0;
      out_imm <= '0;
    end else if (flush) begin
      pend <= 1'b0;
      out_valid <= 1'b0;
    end else if (!in_valid) begin
      out_valid <= 1'b0;
    end else if (!pend && is_pfx) begin
      pend <= 1'b1;
      out_valid <= 1'b0;
      p_disp <= in_word[17:0];
      p_form <= in_word[25:24];
      p_sub <= in_word[23];
      p_rel <= in_word[20];
      p_lo <= in_addr[OVL_HI:2];
    end else if (pend) begin
      pend <= 1'b0;
      out_valid <= 1'b1;
      out_word <= in_word;
      out_code <= in_code | CODE_W'(1);
      out_addr <= fused_addr;
      out_prefixed <= 1'b1;
      out_pfx_ok <= form_ok && !is_pfx;
      out_pcrel <= form_ls && p_rel && !is_pfx;
      out_illegal <= is_pfx || in_code == ILLEGAL_CODE;
      out_imm <= {{(64-DISP_W){disp34[DISP_W-1]}}, disp34};
    end else begin
      out_valid <= 1'b1;
      out_word <= in_word;
      out_code <= in_code;
      out_addr <= in_addr;
      out_prefixed <= 1'b0;
      out_pfx_ok <= 1'b0;
      out_pcrel <= 1'b0;
      out_illegal <= in_code == ILLEGAL_CODE || in_code == PH_LOAD_CODE ||
                     in_code == PH_STORE_CODE;
      out_imm <= {{48{in_word[15]}}, in_word[15:0]};
    end
  end

  // R1
  prefix_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && !pend && is_pfx) |=> !out_valid);

  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  // R3
  fused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && pend && !is_pfx) |=>
      (out_valid && out_prefixed && out_code == ($past(in_code) | CODE_W'(1))));

  // R4
  fused_upper_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && pend) |=>
      out_addr[ADDR_W-1:OVL_HI+1] == $past(in_addr[ADDR_W-1:OVL_HI+1]));

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && !pend && !is_pfx) |=>
      (out_valid && !out_prefixed && out_addr == $past(in_addr)));

  // R9
  double_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flush && pend && is_pfx) |=> (out_valid && out_illegal));
endmodule

// File: tb/prefix_fuse_test.sv
module prefix_fuse_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [9:0]  in_code = '0;
  logic [63:0] in_addr = '0;
  logic        out_valid, out_prefixed, out_pfx_ok, out_pcrel, out_illegal;
  logic [31:0] out_word;
  logic [9:0]  out_code;
  logic [63:0] out_addr, out_imm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prefix_fuse uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_word(in_word), .in_code(in_code), .in_addr(in_addr),
    .out_valid(out_valid), .out_word(out_word), .out_code(out_code),
    .out_addr(out_addr), .out_prefixed(out_prefixed), .out_pfx_ok(out_pfx_ok),
    .out_pcrel(out_pcrel), .out_illegal(out_illegal), .out_imm(out_imm)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pfx(input logic [1:0] form, input logic sub,
                                      input logic r, input logic [17:0] d);
    return {6'd1, form, sub, 2'b00, r, 2'b00, d};
  endfunction

  task automatic step(input logic v, input logic f, input logic [31:0] w,
                      input logic [9:0] c, input logic [63:0] a);
    @(negedge clk);
    in_valid = v; flush = f; in_word = w; in_code = c; in_addr = a;
    @(posedge clk);
    #1;
    in_valid = 1'b0; flush = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 valid after reset", 64'(out_valid), 64'd0);
    step(1'b1, 1'b0, 32'h3860_0001, 10'd40, 64'h100);
    chk("R12 no pending after reset", 64'(out_prefixed), 64'd0);
  endtask

  task automatic t_plain();
    step(1'b1, 1'b0, 32'h3860_FFFC, 10'd40, 64'h1000);
    chk("R11 valid", 64'(out_valid), 64'd1);
    chk("R11 code", 64'(out_code), 64'd40);
    chk("R11 addr", out_addr, 64'h1000);
    chk("R11 word", 64'(out_word), 64'h3860_FFFC);
    chk("R11 imm", out_imm, 64'hFFFF_FFFF_FFFF_FFFC);
    chk("R11 prefixed", 64'(out_prefixed), 64'd0);
    chk("R6 pcrel unprefixed", 64'(out_pcrel), 64'd0);
    chk("R7 ok unprefixed", 64'(out_pfx_ok), 64'd0);
    chk("R8 legal", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_fuse_neg();
    step(1'b1, 1'b0, pfx(2'b10, 1'b0, 1'b1, 18'h3FFFF), 10'd1, 64'h2038);
    chk("R1 prefix silent", 64'(out_valid), 64'd0);
    step(1'b0, 1'b0, 32'h0, 10'd0, 64'h0);
    chk("R2 idle silent", 64'(out_valid), 64'd0);
    step(1'b0, 1'b0, 32'h0, 10'd0, 64'h0);
    step(1'b1, 1'b0, 32'h3860_0004, 10'd40, 64'h203C);
    chk("R2 suffix after idle valid", 64'(out_valid), 64'd1);
    chk("R3 code", 64'(out_code), 64'd41);
    chk("R3 prefixed", 64'(out_prefixed), 64'd1);
    chk("R3 word", 64'(out_word), 64'h3860_0004);
    chk("R4 addr", out_addr, 64'h2038);
    chk("R5 imm neg", out_imm, 64'hFFFF_FFFF_FFFF_0004);
    chk("R6 pcrel", 64'(out_pcrel), 64'd1);
    chk("R7 ok mls", 64'(out_pfx_ok), 64'd1);
    chk("R8 legal fused", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_fuse_pos();
    step(1'b1, 1'b0, pfx(2'b00, 1'b0, 1'b0, 18'h12345), 10'd1, 64'hABC0_0000_0000_2000);
    step(1'b1, 1'b0, 32'h3860_ABCD, 10'd52, 64'hABC0_0000_0000_2004);
    chk("R4 addr pos", out_addr, 64'hABC0_0000_0000_2000);
    chk("R5 imm pos", out_imm, 64'h0000_0001_2345_ABCD);
    chk("R6 pcrel clear", 64'(out_pcrel), 64'd0);
    chk("R7 ok 8ls", 64'(out_pfx_ok), 64'd1);
    chk("R3 code pos", 64'(out_code), 64'd53);
  endtask

  task automatic t_bad_form();
    step(1'b1, 1'b0, pfx(2'b01, 1'b0, 1'b1, 18'h0), 10'd1, 64'h3000);
    step(1'b1, 1'b0, 32'h3860_0000, 10'd40, 64'h3004);
    chk("R7 bad form", 64'(out_pfx_ok), 64'd0);
    chk("R6 bad form pcrel", 64'(out_pcrel), 64'd0);
    chk("R7 code unaffected", 64'(out_code), 64'd41);
    step(1'b1, 1'b0, pfx(2'b10, 1'b1, 1'b1, 18'h0), 10'd1, 64'h3010);
    step(1'b1, 1'b0, 32'h3860_0000, 10'd40, 64'h3014);
    chk("R7 mls subtype", 64'(out_pfx_ok), 64'd0);
    chk("R6 mls subtype pcrel", 64'(out_pcrel), 64'd1);
  endtask

  task automatic t_placeholder();
    step(1'b1, 1'b0, {6'd57, 26'h0}, 10'd200, 64'h4000);
    chk("R8 load placeholder illegal", 64'(out_illegal), 64'd1);
    step(1'b1, 1'b0, {6'd61, 26'h0}, 10'd202, 64'h4004);
    chk("R8 store placeholder illegal", 64'(out_illegal), 64'd1);
    step(1'b1, 1'b0, 32'h0, 10'd0, 64'h4008);
    chk("R8 illegal code", 64'(out_illegal), 64'd1);
    step(1'b1, 1'b0, pfx(2'b00, 1'b0, 1'b0, 18'h0), 10'd1, 64'h4010);
    step(1'b1, 1'b0, {6'd61, 26'h8}, 10'd202, 64'h4014);
    chk("R8 prefixed store code", 64'(out_code), 64'd203);
    chk("R8 prefixed store legal", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_double();
    step(1'b1, 1'b0, pfx(2'b00, 1'b0, 1'b0, 18'h0), 10'd1, 64'h5000);
    step(1'b1, 1'b0, pfx(2'b00, 1'b0, 1'b0, 18'h0), 10'd1, 64'h5004);
    chk("R9 valid", 64'(out_valid), 64'd1);
    chk("R9 illegal", 64'(out_illegal), 64'd1);
    chk("R9 prefixed", 64'(out_prefixed), 64'd1);
    step(1'b1, 1'b0, 32'h3860_0000, 10'd40, 64'h5008);
    chk("R9 cleared pending", 64'(out_prefixed), 64'd0);
    chk("R9 cleared addr", out_addr, 64'h5008);
  endtask

  task automatic t_flush();
    step(1'b1, 1'b0, pfx(2'b00, 1'b0, 1'b0, 18'h0), 10'd1, 64'h6000);
    step(1'b0, 1'b1, 32'h0, 10'd0, 64'h0);
    chk("R10 flush quiet", 64'(out_valid), 64'd0);
    step(1'b1, 1'b0, 32'h3860_0000, 10'd40, 64'h6004);
    chk("R10 pending dropped", 64'(out_prefixed), 64'd0);
    chk("R10 own addr", out_addr, 64'h6004);
    step(1'b1, 1'b1, 32'h3860_0000, 10'd40, 64'h6008);
    chk("R10 input dropped", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_fuse_neg();
    t_fuse_pos();
    t_bad_form();
    t_placeholder();
    t_double();
    t_flush();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule